// File: doc/BRIEF.md
# Two-Phase Fixed Off-Time Current Chopper

This block is the digital chopping controller for a two-phase stepper bridge. Each phase receives an over-threshold flag from an external current comparator. From that flag the block produces a drive state for the phase's full bridge: drive, slow decay, fast decay or all-off. A trip ends the drive period, and the phase then decays for a fixed, programmed number of clock cycles before it drives again. Two guards keep switching noise from chopping the bridge. The comparator is ignored for a blanking interval after every turn-on. Drive also lasts at least a minimum on-time, which is the blanking time plus a fault-sampling window.

The decay style depends on the step that set the current level. It comes from a mode input only when that step commanded less current than the step before. Any other step gives slow decay. The block also keeps the microstep position counter. A disable input turns off the bridges but leaves stepping running. A sleep input turns everything off and returns the position to home. All timings are cycle counts supplied on inputs.

Top module: `chopper_top`

## Requirements
- R1: Each of the two phases has its own state machine, trip input and bridge output. A phase's bridge code is 2'b00 all-off, 2'b01 drive, 2'b10 slow decay and 2'b11 fast decay.
- R2: After a phase leaves drive, it decays for max(t_off_i, 1) cycles and then returns to drive.
- R3: Drive cannot end before t_blank_i + t_fsamp_i cycles have passed. With the trip held active, drive lasts exactly max(t_blank_i + t_fsamp_i, t_blank_i + 1) cycles.
- R4: Each trip input passes through two flops. A synchronized trip seen in the first t_blank_i cycles of drive is ignored. A trip seen after blanking but before the minimum on-time ends is remembered, and it ends drive when the minimum on-time ends.
- R5: At each step, the phase latches a decay mode. If the new level_i is lower than the level of the previous step, decay_sel_i picks the mode: 0 slow, 1 mixed, 2 fast, 3 slow. Otherwise the mode is slow. In mixed mode the first t_fast_i decay cycles are fast and the rest are slow.
- R6: When disable_i is high, both bridges are all-off from the next cycle. The position keeps counting steps. After release, each phase restarts in drive.
- R7: When sleep_n is low, both bridges are all-off and steps are ignored. The position is held at home (0) and is still 0 after wake-up.
- R8: While awake, a step_i pulse moves pos_o by +1 when dir_i is 1 and by -1 when dir_i is 0, wrapping modulo 2^POS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_n | input | 1 | Low puts the block to sleep and homes the position |
| disable_i | input | 1 | High forces both bridges all-off |
| step_i | input | 1 | Single-cycle step pulse |
| dir_i | input | 1 | Step direction, 1 counts up |
| decay_sel_i | input | 2 | Decay style applied to a current-lowering step |
| t_off_i | input | CNT_W | Decay time in cycles |
| t_blank_i | input | CNT_W | Blanking time in cycles |
| t_fsamp_i | input | CNT_W | Fault-sampling extension of the on-time |
| t_fast_i | input | CNT_W | Fast portion of mixed decay in cycles |
| level_i | input | 2*LVL_W | Commanded level per phase, valid with step_i |
| trip_i | input | 2 | Asynchronous comparator flags, one per phase |
| bridge_o | output | 4 | Bridge code per phase, 2 bits each |
| pos_o | output | POS_W | Microstep position |

## Verification
A wrong counter load or a faulty leave condition changes the length of the drive or decay runs on bridge_o. That shows up within one chopping period as a run that is one cycle too long or too short. A wrong blanking or pending-trip state shows as drive that ends too early or never ends, visible about t_blank_i + t_fsamp_i cycles after turn-on. A wrongly latched decay mode changes the count of 2'b11 cycles in the first decay after the step. A position fault shows on pos_o one cycle after the step, or right after sleep.

// File: rtl/chop_pkg.sv
// Shared encodings for the two-phase current chopper.
package chop_pkg;
    // Bridge drive code seen at the port
    typedef enum logic [1:0] {
        BR_OFF   = 2'b00,
        BR_DRIVE = 2'b01,
        BR_SLOW  = 2'b10,
        BR_FAST  = 2'b11
    } bridge_e;

    // Decay style latched per phase at each step
    typedef enum logic [1:0] {
        DK_SLOW  = 2'd0,
        DK_MIXED = 2'd1,
        DK_FAST  = 2'd2,
        DK_RSVD  = 2'd3
    } decay_e;

    // Per-phase chopping state
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ON    = 2'd1,
        PH_DECAY = 2'd2
    } phase_e;
endpackage

// File: rtl/chop_sync2.sv
// Two-flop synchronizer for asynchronous comparator flags.
// Assumes each bit is an independent level signal. Synchronous active-low reset.
module chop_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages bring d_i into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/chop_decay_sel.sv
// Latches a phase's decay style at each step. The mode input counts only when
// the new level is below the previous step's level; otherwise the style is slow.
// Assumes level_i is valid in the cycle step_i is high. Sleep clears the history.
module chop_decay_sel
    import chop_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_n,
    input  logic             step_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [1:0]       sel_i,
    output decay_e           mode_o
);
    logic [LVL_W-1:0] prev_q;
    logic             lower;
    decay_e           pick;

    // Lowering test and mapping of the reserved code to slow
    always_comb begin
        lower = level_i < prev_q;
        pick  = (decay_e'(sel_i) == DK_RSVD) ? DK_SLOW : decay_e'(sel_i);
    end

    // Keep the previous level and the latched style
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_n) begin
            prev_q <= '0;
            mode_o <= DK_SLOW;
        end else if (step_i) begin
            prev_q <= level_i;
            mode_o <= lower ? pick : DK_SLOW;
        end
    end

    assert_raise_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_n && step_i && !(level_i < prev_q)) |=> mode_o == DK_SLOW);
    assert_no_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != DK_RSVD);
endmodule

// File: rtl/chop_phase.sv
// One phase's chopping state machine. Drive runs for at least blank+fsamp cycles,
// the trip is ignored during blanking, and a trip taken after blanking ends drive.
// Decay then lasts t_off cycles in the latched style.
// Assumes trip_i is already synchronized and the timing inputs are quasi-static.
module chop_phase
    import chop_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic             trip_i,
    input  decay_e           mode_i,
    input  logic [CNT_W-1:0] t_off_i,
    input  logic [CNT_W-1:0] t_blank_i,
    input  logic [CNT_W-1:0] t_fsamp_i,
    input  logic [CNT_W-1:0] t_fast_i,
    output bridge_e          bridge_o
);
    localparam int OW = CNT_W + 1;

    phase_e           st_q;
    logic [OW-1:0]    on_cnt;
    logic [CNT_W-1:0] off_cnt;
    logic [CNT_W-1:0] fast_cnt;
    logic             pend_q;
    logic [OW-1:0]    min_len;
    logic             blanked;
    logic             accept;
    logic             leave_on;
    logic             leave_off;

    // Interval decode from the down-counters
    always_comb begin
        min_len   = {1'b0, t_blank_i} + {1'b0, t_fsamp_i};
        blanked   = on_cnt > {1'b0, t_fsamp_i};
        accept    = trip_i && !blanked;
        leave_on  = (on_cnt <= OW'(1)) && (pend_q || accept);
        leave_off = off_cnt <= CNT_W'(1);
    end

    // State and timer sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= PH_IDLE;
            on_cnt   <= '0;
            off_cnt  <= '0;
            fast_cnt <= '0;
            pend_q   <= 1'b0;
        end else if (idle_i) begin
            st_q   <= PH_IDLE;
            pend_q <= 1'b0;
        end else begin
            case (st_q)
                PH_ON: begin
                    if (leave_on) begin
                        st_q     <= PH_DECAY;
                        off_cnt  <= t_off_i;
                        fast_cnt <= t_fast_i;
                        pend_q   <= 1'b0;
                    end else begin
                        if (on_cnt != '0) on_cnt <= on_cnt - OW'(1);
                        if (accept) pend_q <= 1'b1;
                    end
                end
                PH_DECAY: begin
                    if (leave_off) begin
                        st_q   <= PH_ON;
                        on_cnt <= min_len;
                        pend_q <= 1'b0;
                    end else begin
                        off_cnt <= off_cnt - CNT_W'(1);
                        if (fast_cnt != '0) fast_cnt <= fast_cnt - CNT_W'(1);
                    end
                end
                default: begin
                    st_q   <= PH_ON;
                    on_cnt <= min_len;
                    pend_q <= 1'b0;
                end
            endcase
        end
    end

    // Bridge code from state and decay style
    always_comb begin
        case (st_q)
            PH_ON:    bridge_o = BR_DRIVE;
            PH_DECAY: begin
                case (mode_i)
                    DK_FAST:  bridge_o = BR_FAST;
                    DK_MIXED: bridge_o = (fast_cnt != '0) ? BR_FAST : BR_SLOW;
                    default:  bridge_o = BR_SLOW;
                endcase
            end
            default:  bridge_o = BR_OFF;
        endcase
    end

    assert_min_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_ON && on_cnt > OW'(1)) |=> st_q != PH_DECAY);
    assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_DECAY && off_cnt > CNT_W'(1)) |=> st_q != PH_ON);
    assert_blank_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_ON && on_cnt > {1'b0, t_fsamp_i}) |-> !pend_q);
    assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_IDLE) |-> bridge_o == BR_OFF);
endmodule

// File: rtl/chopper_top.sv
// Two-phase fixed off-time chopper with decay selection and position counter.
// Assumes step_i is a one-cycle synchronous pulse and trip_i is asynchronous.
module chopper_top
    import chop_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LVL_W = 5,
    parameter int POS_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_n,
    input  logic                  disable_i,
    input  logic                  step_i,
    input  logic                  dir_i,
    input  logic [1:0]            decay_sel_i,
    input  logic [CNT_W-1:0]      t_off_i,
    input  logic [CNT_W-1:0]      t_blank_i,
    input  logic [CNT_W-1:0]      t_fsamp_i,
    input  logic [CNT_W-1:0]      t_fast_i,
    input  logic [1:0][LVL_W-1:0] level_i,
    input  logic [1:0]            trip_i,
    output logic [1:0][1:0]       bridge_o,
    output logic [POS_W-1:0]      pos_o
);
    localparam int NPH = 2;

    logic [NPH-1:0] trip_s;
    logic           idle;
    logic           awake_step;

    assign idle       = disable_i || !sleep_n;
    assign awake_step = step_i && sleep_n;

    chop_sync2 #(.W(NPH)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (trip_i),
        .q_o   (trip_s)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        decay_e  mode;
        bridge_e br;

        chop_decay_sel #(.LVL_W(LVL_W)) i_dsel (
            .clk     (clk),
            .rst_n   (rst_n),
            .sleep_n (sleep_n),
            .step_i  (step_i),
            .level_i (level_i[p]),
            .sel_i   (decay_sel_i),
            .mode_o  (mode)
        );

        chop_phase #(.CNT_W(CNT_W)) i_phase (
            .clk       (clk),
            .rst_n     (rst_n),
            .idle_i    (idle),
            .trip_i    (trip_s[p]),
            .mode_i    (mode),
            .t_off_i   (t_off_i),
            .t_blank_i (t_blank_i),
            .t_fsamp_i (t_fsamp_i),
            .t_fast_i  (t_fast_i),
            .bridge_o  (br)
        );

        assign bridge_o[p] = br;
    end

    // Microstep position: homed in sleep, counts steps otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_n) begin
            pos_o <= '0;
        end else if (awake_step) begin
            pos_o <= dir_i ? pos_o + POS_W'(1) : pos_o - POS_W'(1);
        end
    end

    assert_force_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_i || !sleep_n) |=> bridge_o == '0);
    assert_sleep_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> pos_o == '0);
    assert_step_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_n && step_i && dir_i) |=> pos_o == POS_W'($past(pos_o) + 1'b1));
endmodule

// File: tb/test_chopper_top.sv
module test_chopper_top;
    localparam int CNT_W = 8;
    localparam int LVL_W = 5;
    localparam int POS_W = 4;
    localparam logic [1:0] B_OFF = 2'b00, B_ON = 2'b01, B_SLOW = 2'b10, B_FAST = 2'b11;

    // Row: off, blank, fsamp, fast, mode, lowering step
    localparam int NV = 9;
    localparam logic [34:0] VEC [NV] = '{
        {8'd6,  8'd3, 8'd2, 8'd0,  2'd0, 1'b1},
        {8'd6,  8'd3, 8'd2, 8'd0,  2'd2, 1'b1},
        {8'd8,  8'd2, 8'd3, 8'd3,  2'd1, 1'b1},
        {8'd8,  8'd2, 8'd3, 8'd3,  2'd1, 1'b0},
        {8'd4,  8'd4, 8'd0, 8'd2,  2'd2, 1'b0},
        {8'd1,  8'd0, 8'd0, 8'd5,  2'd1, 1'b1},
        {8'd10, 8'd1, 8'd1, 8'd12, 2'd1, 1'b1},
        {8'd3,  8'd5, 8'd5, 8'd1,  2'd2, 1'b1},
        {8'd5,  8'd2, 8'd2, 8'd0,  2'd3, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, sleep_n = 1'b1, disable_i = 1'b0, step_i = 1'b0, dir_i = 1'b1;
    logic [1:0] decay_sel_i = 2'd0;
    logic [CNT_W-1:0] t_off_i = 8'd4, t_blank_i = 8'd2, t_fsamp_i = 8'd2, t_fast_i = 8'd0;
    logic [1:0][LVL_W-1:0] level_i = '0;
    logic [1:0] trip_i = 2'b00;
    logic [1:0][1:0] bridge_o;
    logic [POS_W-1:0] pos_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chopper_top #(.CNT_W(CNT_W), .LVL_W(LVL_W), .POS_W(POS_W)) i_chopper_top (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .disable_i(disable_i),
        .step_i(step_i), .dir_i(dir_i), .decay_sel_i(decay_sel_i),
        .t_off_i(t_off_i), .t_blank_i(t_blank_i), .t_fsamp_i(t_fsamp_i),
        .t_fast_i(t_fast_i), .level_i(level_i), .trip_i(trip_i),
        .bridge_o(bridge_o), .pos_o(pos_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_step(input logic d, input int lvl);
        @(negedge clk);
        step_i = 1'b1; dir_i = d; level_i = {LVL_W'(lvl), LVL_W'(lvl)};
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); disable_i = 1'b1;
        repeat (3) @(negedge clk);
        disable_i = 1'b0;
    endtask

    // Lengths of one decay period and the following drive period on phase 0
    task automatic measure(output int on_len, output int off_len, output int fast_n);
        int g;
        on_len = 0; off_len = 0; fast_n = 0;
        g = 0;
        while (bridge_o[0] != B_ON && g < 200) begin @(negedge clk); g++; end
        while (bridge_o[0] == B_ON && g < 400) begin @(negedge clk); g++; end
        while (bridge_o[0] != B_ON && g < 600) begin
            off_len++;
            if (bridge_o[0] == B_FAST) fast_n++;
            @(negedge clk); g++;
        end
        while (bridge_o[0] == B_ON && g < 800) begin on_len++; @(negedge clk); g++; end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        int on_l, off_l, fst;
        int e_on, e_off, e_fast;
        // Reset state
        repeat (3) @(negedge clk);
        chk("R1 reset bridge", int'(bridge_o), 0);
        chk("R8 reset pos", int'(pos_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 drive after reset", int'(bridge_o[0]), int'(B_ON));

        // Table walk with trip held high on both phases
        trip_i = 2'b11;
        for (int r = 0; r < NV; r++) begin
            t_off_i = VEC[r][34:27]; t_blank_i = VEC[r][26:19];
            t_fsamp_i = VEC[r][18:11]; t_fast_i = VEC[r][10:3];
            decay_sel_i = VEC[r][2:1];
            do_step(1'b1, 8);
            do_step(1'b1, VEC[r][0] ? 4 : 12);
            restart();
            measure(on_l, off_l, fst);
            e_on  = (int'(t_blank_i) + int'(t_fsamp_i) > int'(t_blank_i) + 1) ?
                    int'(t_blank_i) + int'(t_fsamp_i) : int'(t_blank_i) + 1;
            e_off = (t_off_i == 0) ? 1 : int'(t_off_i);
            if (!VEC[r][0] || decay_sel_i == 2'd0 || decay_sel_i == 2'd3) e_fast = 0;
            else if (decay_sel_i == 2'd2) e_fast = e_off;
            else e_fast = (int'(t_fast_i) < e_off) ? int'(t_fast_i) : e_off;
            chk($sformatf("R3 on length row %0d", r), on_l, e_on);
            chk($sformatf("R2 off length row %0d", r), off_l, e_off);
            chk($sformatf("R5 fast cycles row %0d", r), fst, e_fast);
        end

        // Blanking: trip visible only inside blanking is ignored
        t_off_i = 8'd6; t_blank_i = 8'd4; t_fsamp_i = 8'd4;
        @(negedge clk); disable_i = 1'b1; trip_i = 2'b00;
        repeat (3) @(negedge clk);
        disable_i = 1'b0;
        on_l = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (bridge_o[0] == B_ON) on_l++;
            trip_i[0] = (k == 0);
        end
        chk("R4 trip in blanking ignored", on_l, 40);

        // Trip after blanking is held and ends drive at the minimum on-time
        @(negedge clk); disable_i = 1'b1; trip_i = 2'b00;
        repeat (3) @(negedge clk);
        disable_i = 1'b0;
        on_l = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (bridge_o[0] == B_ON && on_l == k) on_l++;
            trip_i[0] = (k == 3);
        end
        chk("R4 pending trip ends drive", on_l, 8);

        // Ramp current model on phase 1
        begin
            int cur = 0, run = 0, on_bad = 0, off_bad = 0, chops = 0;
            logic [1:0] prev;
            t_off_i = 8'd5; t_blank_i = 8'd2; t_fsamp_i = 8'd2; t_fast_i = 8'd0;
            do_step(1'b1, 20);
            restart();
            @(negedge clk);
            prev = bridge_o[1];
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (bridge_o[1] == prev) run++;
                else begin
                    if (prev == B_ON && bridge_o[1] != B_ON) begin
                        chops++;
                        if (chops > 1 && run + 1 < 4) on_bad++;
                    end
                    if (prev != B_ON && bridge_o[1] == B_ON && chops > 0 && run + 1 != 5) off_bad++;
                    run = 0;
                end
                prev = bridge_o[1];
                if (bridge_o[1] == B_ON) cur += 3;
                else if (bridge_o[1] == B_FAST) cur -= 3;
                else if (bridge_o[1] == B_SLOW) cur -= 1;
                trip_i[1] = (cur >= 40);
            end
            chk("R1 phase 1 chops under ramp", int'(chops > 3), 1);
            chk("R3 ramp drive not short", on_bad, 0);
            chk("R2 ramp decay length", off_bad, 0);
        end

        // Disable: bridges off, stepping continues, restart in drive
        @(negedge clk); disable_i = 1'b1;
        @(negedge clk);
        chk("R6 disable forces off", int'(bridge_o), 0);
        begin
            logic [POS_W-1:0] p0;
            p0 = pos_o;
            do_step(1'b1, 10);
            do_step(1'b1, 10);
            @(negedge clk);
            chk("R6 position runs while disabled", int'(pos_o), int'(POS_W'(p0 + 2)));
        end
        disable_i = 1'b0;
        @(negedge clk);
        chk("R6 restart in drive", int'(bridge_o[0]), int'(B_ON));

        // Sleep: off, homed, steps ignored
        sleep_n = 1'b0;
        @(negedge clk);
        chk("R7 sleep bridge off", int'(bridge_o), 0);
        chk("R7 sleep homes position", int'(pos_o), 0);
        do_step(1'b1, 10);
        @(negedge clk);
        chk("R7 step ignored in sleep", int'(pos_o), 0);
        sleep_n = 1'b1;
        @(negedge clk);
        chk("R7 home after wake", int'(pos_o), 0);
        chk("R7 drive after wake", int'(bridge_o[0]), int'(B_ON));
        do_step(1'b0, 10);
        @(negedge clk);
        chk("R8 step down wraps", int'(pos_o), (1 << POS_W) - 1);
        do_step(1'b1, 10);
        do_step(1'b1, 10);
        @(negedge clk);
        chk("R8 step up", int'(pos_o), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule